// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block stores four 16-bit segment base registers, one each for code, stack, data and extra space, and turns a segment choice plus a 16-bit offset into a 20-bit physical address. A requester names the segment and either gives an explicit offset or asks for the default pointer paired with that segment. The pointer values come in on input ports from the register file that owns them. The block shifts the segment value left by four bits, adds the offset, and drops any carry above bit 19. The result is registered and comes out with a valid strobe one cycle after the request.

Segment registers are loaded through a write port. A write changes the register at the clock edge, so a request made in the same cycle as the write still sees the old value. The output stage is a two-state machine. In ST_IDLE no address is valid. In ST_OUT the registered address is valid. The transitions are: IDLE->OUT on a request, OUT->OUT on a request, OUT->IDLE when there is no request, and IDLE->IDLE when there is no request.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, pa_valid is 0, pa_addr is 0 and all four segment registers hold 0.
- R2: For an explicit offset (req_use_dflt=0), pa_addr = (segment*16 + req_offset) mod 2^20. For example, segment 1234h with offset 0011h gives 12351h.
- R3: A carry out of bit 19 is discarded. Segment FFFFh with offset 0010h gives 00000h, and FFFFh with FFFFh gives 0FFEFh.
- R4: The 2-bit segment codes on req_sel and seg_wr_sel are 00 extra, 01 code, 10 stack and 11 data.
- R5: With req_use_dflt=1, the offset used is ptr_ip for code, ptr_si for data and ptr_di for extra. For stack it is ptr_sp, or ptr_bp when req_use_bp=1. req_use_bp has no effect for the other three segments.
- R6: A segment write takes effect for requests issued in the following cycle. A request in the same cycle as the write uses the old value.
- R7: A request sampled at a clock edge gives pa_valid=1 with its address in the cycle after that edge. Back-to-back requests give back-to-back results.
- R8: In a cycle with no request, the next cycle has pa_valid=0 and pa_addr holds its last value.
- R9: A write to one segment register leaves the other three unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Segment code of the register to load |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request |
| req_sel | input | 2 | Segment code for the request |
| req_use_dflt | input | 1 | Use the paired default pointer instead of req_offset |
| req_use_bp | input | 1 | For stack with default pointer: use base pointer |
| req_offset | input | 16 | Explicit offset |
| ptr_ip | input | 16 | Instruction pointer value |
| ptr_sp | input | 16 | Stack pointer value |
| ptr_bp | input | 16 | Base pointer value |
| ptr_si | input | 16 | Source index value |
| ptr_di | input | 16 | Destination index value |
| pa_valid | output | 1 | Physical address valid |
| pa_addr | output | 20 | Physical address |

## Verification
The bench tests wraparound at the top of the 1 MB space. A design that kept the carry, or shifted by the wrong amount, would give wrong upper address bits there. It issues a request in the same cycle as a segment write. A register bypass would show the new base one cycle early. Writing distinct bases into each register and reading every pairing back exposes swapped segment codes or swapped default pointers, including the stack pointer and base pointer choice. Idle cycles and back-to-back requests expose a valid strobe that sticks high or lags by a cycle, and an address that changes while idle.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } out_state_e;
endpackage

// File: rtl/seg_base_regs.sv
module seg_base_regs #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                seg_q[g] <= wr_data;
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(g)) |=> (seg_q[g] == $past(wr_data))); // R6
        AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(seg_q[g])); // R9
    end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    localparam int SHIFT = PA_W - SEG_W
) (
    input  logic [3:0][SEG_W-1:0] seg_q,
    input  logic [1:0]            sel,
    input  logic                  use_dflt,
    input  logic                  use_bp,
    input  logic [OFF_W-1:0]      offset,
    input  logic [OFF_W-1:0]      ptr_ip,
    input  logic [OFF_W-1:0]      ptr_sp,
    input  logic [OFF_W-1:0]      ptr_bp,
    input  logic [OFF_W-1:0]      ptr_si,
    input  logic [OFF_W-1:0]      ptr_di,
    output logic [PA_W-1:0]       pa
);
    logic [OFF_W-1:0] dflt_off;
    logic [OFF_W-1:0] eff_off;
    logic [PA_W-1:0]  base;

    always_comb begin
        unique case (seg_sel_e'(sel))
            SEG_CODE:  dflt_off = ptr_ip;
            SEG_STACK: dflt_off = use_bp ? ptr_bp : ptr_sp;
            SEG_DATA:  dflt_off = ptr_si;
            SEG_EXTRA: dflt_off = ptr_di;
            default:   dflt_off = '0;
        endcase
    end

    assign eff_off = use_dflt ? dflt_off : offset;
    assign base    = {seg_q[sel], {SHIFT{1'b0}}};
    assign pa      = base + {{(PA_W-OFF_W){1'b0}}, eff_off};
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_wr_en,
    input  logic [1:0]       seg_wr_sel,
    input  logic [SEG_W-1:0] seg_wr_data,
    input  logic             req_valid,
    input  logic [1:0]       req_sel,
    input  logic             req_use_dflt,
    input  logic             req_use_bp,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [OFF_W-1:0] ptr_ip,
    input  logic [OFF_W-1:0] ptr_sp,
    input  logic [OFF_W-1:0] ptr_bp,
    input  logic [OFF_W-1:0] ptr_si,
    input  logic [OFF_W-1:0] ptr_di,
    output logic             pa_valid,
    output logic [PA_W-1:0]  pa_addr
);
    logic [3:0][SEG_W-1:0] seg_q;
    logic [PA_W-1:0]       pa_next;
    out_state_e            state_q, state_d;
    logic [PA_W-1:0]       addr_q;

    seg_base_regs #(.SEG_W(SEG_W), .NSEG(4)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_q)
    );

    seg_addr_calc #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_calc (
        .seg_q    (seg_q),
        .sel      (req_sel),
        .use_dflt (req_use_dflt),
        .use_bp   (req_use_bp),
        .offset   (req_offset),
        .ptr_ip   (ptr_ip),
        .ptr_sp   (ptr_sp),
        .ptr_bp   (ptr_bp),
        .ptr_si   (ptr_si),
        .ptr_di   (ptr_di),
        .pa       (pa_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = req_valid ? ST_OUT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (req_valid)
            addr_q <= pa_next;
    end

    assign pa_valid = (state_q == ST_OUT);
    assign pa_addr  = addr_q;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pa_valid); // R7
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pa_valid); // R8
    AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(pa_addr)); // R8
    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_use_dflt) |=> (pa_addr[3:0] == $past(req_offset[3:0]))); // R2
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic        req_use_dflt = 1'b0;
    logic        req_use_bp = 1'b0;
    logic [15:0] req_offset = '0;
    logic [15:0] ptr_ip = 16'h0111;
    logic [15:0] ptr_sp = 16'h0222;
    logic [15:0] ptr_bp = 16'h0333;
    logic [15:0] ptr_si = 16'h0444;
    logic [15:0] ptr_di = 16'h0555;
    logic        pa_valid;
    logic [19:0] pa_addr;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] m_seg [4];

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_sel(req_sel), .req_use_dflt(req_use_dflt),
        .req_use_bp(req_use_bp), .req_offset(req_offset),
        .ptr_ip(ptr_ip), .ptr_sp(ptr_sp), .ptr_bp(ptr_bp), .ptr_si(ptr_si), .ptr_di(ptr_di),
        .pa_valid(pa_valid), .pa_addr(pa_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [19:0] exp_pa(input logic [15:0] seg, input logic [15:0] off);
        logic [20:0] full;
        full = {1'b0, seg, 4'h0} + {5'h0, off};
        return full[19:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
        m_seg[sel] = val;
    endtask

    task automatic do_req(input string req, input logic [1:0] sel, input logic dflt,
                          input logic bp, input logic [15:0] off, input logic [19:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_use_dflt = dflt; req_use_bp = bp; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {31'h0, pa_valid}, 32'h1);
        check(req, {12'h0, pa_addr}, {12'h0, exp});
    endtask

    task automatic t_reset();
        check("R1 valid", {31'h0, pa_valid}, 32'h0);
        check("R1 addr", {12'h0, pa_addr}, 32'h0);
        for (int s = 0; s < 4; s++)
            do_req("R1 seg zero", 2'(s), 1'b0, 1'b0, 16'h0ABC, 20'h00ABC);
    endtask

    task automatic t_example();
        wr_seg(2'b11, 16'h1234);
        do_req("R2 example", 2'b11, 1'b0, 1'b0, 16'h0011, 20'h12351);
        do_req("R2 pattern", 2'b11, 1'b0, 1'b0, 16'hF00F, exp_pa(16'h1234, 16'hF00F));
    endtask

    task automatic t_encoding();
        wr_seg(2'b00, 16'h1000);
        wr_seg(2'b01, 16'h2000);
        wr_seg(2'b10, 16'h3000);
        wr_seg(2'b11, 16'h4000);
        do_req("R4 extra=00", 2'b00, 1'b0, 1'b0, 16'h0000, 20'h10000);
        do_req("R4 code=01",  2'b01, 1'b0, 1'b0, 16'h0000, 20'h20000);
        do_req("R4 stack=10", 2'b10, 1'b0, 1'b0, 16'h0000, 20'h30000);
        do_req("R4 data=11",  2'b11, 1'b0, 1'b0, 16'h0000, 20'h40000);
    endtask

    task automatic t_defaults();
        do_req("R5 code ip",   2'b01, 1'b1, 1'b0, 16'hDEAD, exp_pa(16'h2000, 16'h0111));
        do_req("R5 stack sp",  2'b10, 1'b1, 1'b0, 16'hDEAD, exp_pa(16'h3000, 16'h0222));
        do_req("R5 stack bp",  2'b10, 1'b1, 1'b1, 16'hDEAD, exp_pa(16'h3000, 16'h0333));
        do_req("R5 data si",   2'b11, 1'b1, 1'b0, 16'hDEAD, exp_pa(16'h4000, 16'h0444));
        do_req("R5 extra di",  2'b00, 1'b1, 1'b0, 16'hDEAD, exp_pa(16'h1000, 16'h0555));
        do_req("R5 bp ignored code", 2'b01, 1'b1, 1'b1, 16'hDEAD, exp_pa(16'h2000, 16'h0111));
        do_req("R5 bp ignored data", 2'b11, 1'b1, 1'b1, 16'hDEAD, exp_pa(16'h4000, 16'h0444));
    endtask

    task automatic t_wrap();
        wr_seg(2'b00, 16'hFFFF);
        do_req("R3 wrap zero", 2'b00, 1'b0, 1'b0, 16'h0010, 20'h00000);
        do_req("R3 wrap max",  2'b00, 1'b0, 1'b0, 16'hFFFF, 20'h0FFEF);
        do_req("R3 no wrap",   2'b00, 1'b0, 1'b0, 16'h000F, 20'hFFFFF);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = 2'b01; seg_wr_data = 16'h5678;
        req_valid = 1'b1; req_sel = 2'b01; req_use_dflt = 1'b0; req_offset = 16'h0001;
        @(negedge clk);
        seg_wr_en = 1'b0; req_valid = 1'b0;
        check("R6 old value same cycle", {12'h0, pa_addr}, {12'h0, exp_pa(m_seg[1], 16'h0001)});
        m_seg[1] = 16'h5678;
        do_req("R6 new value next cycle", 2'b01, 1'b0, 1'b0, 16'h0001, 20'h56781);
    endtask

    task automatic t_latency();
        @(negedge clk);
        req_valid = 1'b1; req_sel = 2'b11; req_use_dflt = 1'b0; req_offset = 16'h0002;
        check("R7 not valid before edge", {31'h0, pa_valid}, 32'h0);
        @(negedge clk);
        check("R7 first valid", {31'h0, pa_valid}, 32'h1);
        check("R7 first addr", {12'h0, pa_addr}, {12'h0, exp_pa(m_seg[3], 16'h0002)});
        req_sel = 2'b10; req_offset = 16'h0003;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second valid", {31'h0, pa_valid}, 32'h1);
        check("R7 second addr", {12'h0, pa_addr}, {12'h0, exp_pa(m_seg[2], 16'h0003)});
    endtask

    task automatic t_idle();
        logic [19:0] last;
        last = pa_addr;
        req_offset = 16'h7777; req_sel = 2'b00;
        @(negedge clk);
        check("R8 valid low", {31'h0, pa_valid}, 32'h0);
        check("R8 addr held", {12'h0, pa_addr}, {12'h0, last});
        @(negedge clk);
        check("R8 addr still held", {12'h0, pa_addr}, {12'h0, last});
    endtask

    task automatic t_isolation();
        wr_seg(2'b10, 16'hABCD);
        do_req("R9 extra kept", 2'b00, 1'b0, 1'b0, 16'h0000, exp_pa(m_seg[0], 16'h0));
        do_req("R9 code kept",  2'b01, 1'b0, 1'b0, 16'h0000, exp_pa(m_seg[1], 16'h0));
        do_req("R9 data kept",  2'b11, 1'b0, 1'b0, 16'h0000, exp_pa(m_seg[3], 16'h0));
        do_req("R9 stack new",  2'b10, 1'b0, 1'b0, 16'h0000, 20'hABCD0);
    endtask

    initial begin
        for (int s = 0; s < 4; s++) m_seg[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_encoding();
        t_defaults();
        t_wrap();
        t_same_cycle();
        t_latency();
        t_idle();
        t_isolation();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule